// File: doc/BRIEF.md
# Multicast Hash Index Generator

This block sits on the receive nibble path of a media-independent interface. It runs the standard 32-bit Ethernet frame check LFSR over each received frame. Once the six bytes of the destination address are in, it takes a snapshot of the nine top bits of that register. A downstream multicast filter uses the snapshot as the address into its external hash table.

Preamble nibbles are skipped. The LFSR and the byte count start with the first nibble after the start-of-frame delimiter. An index is presented only when the destination address has its group bit set. A valid line qualifies the index and stays high until the frame ends.

Top module: `mc_hash_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `hash_valid_o` is 0 and `hash_idx_o` is 0.
- R2: When `rx_dv_i` rises, every nibble up to and including the first nibble equal to 4'hD (the second half of the delimiter byte) is ignored. The first data nibble is the one that follows it, so the length of the preamble does not change the result.
- R3: The LFSR uses polynomial 0x04C11DB7 and is preset to all ones. It shifts towards the MSB, and the feedback is bit 31 XOR the incoming bit. Each data nibble is processed bit 0 first, and each byte arrives low nibble first.
- R4: After the 12th data nibble, `hash_idx_o` equals bits 31:23 of the LFSR, with bit 31 as the index MSB. The index and `hash_valid_o` appear in the cycle after the clock edge that samples that nibble, and `hash_valid_o` is 0 before that edge.
- R5: A destination address counts as multicast when bit 0 of the first data nibble is 1. For an address with that bit at 0, `hash_valid_o` stays 0 for the whole frame.
- R6: While `rx_dv_i` stays high after the index is presented, `hash_valid_o` stays 1 and `hash_idx_o` does not change, whatever payload follows.
- R7: In the cycle after `rx_dv_i` is sampled low, `hash_valid_o` is 0 and `hash_idx_o` is 0. The LFSR is preset again, so a following frame gets the same index as the same frame sent alone.
- R8: A frame that ends before 12 data nibbles have arrived never raises `hash_valid_o`.
- R9: Whenever `hash_valid_o` is 0, `hash_idx_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_dv_i | input | 1 | Receive data valid |
| rxd_i | input | 4 | Receive nibble, bit 0 first on the wire |
| hash_idx_o | output | 9 | Hash table index (top LFSR bits) |
| hash_valid_o | output | 1 | Index qualifier |

## Verification
Several kinds of internal fault show up in the index value in the same cycle the index is published, one clock after the twelfth address nibble. A wrong LFSR tap, preset or bit order does this. So does a nibble counter that is off by one, or a delimiter match that starts too early. A stale LFSR or a stuck multicast flag shows only on the next frame, as an index that differs from a fresh computation or as a valid strobe on a unicast address. A missed end-of-frame clear shows one cycle after the data valid line drops, as a valid or index line that is still set.

// File: rtl/mc_hash_pkg.sv
package mc_hash_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_PRESET = '1;

  typedef enum logic {
    ST_HUNT,
    ST_DATA
  } rx_state_e;
endpackage

// File: rtl/mc_hash_lfsr_step.sv
module mc_hash_lfsr_step #(
  parameter int unsigned CRC_W = 32,
  parameter int unsigned DW = 4,
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [DW-1:0]    data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] stage [DW+1];

  assign stage[0] = crc_i;

  // bit 0 of the nibble goes in first
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][CRC_W-1] ^ data_i[b];
    assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DW];
endmodule

// File: rtl/mc_hash_seq.sv
module mc_hash_seq
  import mc_hash_pkg::*;
#(
  parameter int unsigned DA_NIBS = 12,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dv_i,
  input  logic [NIB_W-1:0] rxd_i,
  output logic             data_nib_o,
  output logic             first_nib_o,
  output logic             last_da_nib_o
);
  localparam int unsigned CNT_W = $clog2(DA_NIBS + 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  assign data_nib_o    = rx_dv_i && (state_q == ST_DATA);
  assign first_nib_o   = data_nib_o && (cnt_q == '0);
  assign last_da_nib_o = data_nib_o && (cnt_q == CNT_W'(DA_NIBS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else if (!rx_dv_i) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else if (state_q == ST_HUNT) begin
      if (rxd_i == SFD_NIB) state_q <= ST_DATA;
    end else if (cnt_q != CNT_W'(DA_NIBS)) begin
      cnt_q <= cnt_q + 1'b1;  // saturates once the address is in
    end
  end
endmodule

// File: rtl/mc_hash_capture.sv
module mc_hash_capture #(
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dv_i,
  input  logic             first_nib_i,
  input  logic             group_bit_i,
  input  logic             last_da_nib_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  logic mcast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcast_q <= 1'b0;
      idx_o   <= '0;
      valid_o <= 1'b0;
    end else if (!rx_dv_i) begin
      mcast_q <= 1'b0;
      idx_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      if (first_nib_i) mcast_q <= group_bit_i;
      if (last_da_nib_i && mcast_q) begin
        idx_o   <= idx_i;
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mc_hash_gen.sv
module mc_hash_gen
  import mc_hash_pkg::*;
#(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned DA_BYTES = 6,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dv_i,
  input  logic [NIB_W-1:0] rxd_i,
  output logic [IDX_W-1:0] hash_idx_o,
  output logic             hash_valid_o
);
  localparam int unsigned DA_NIBS = DA_BYTES * 8 / NIB_W;

  logic             data_nib, first_nib, last_da_nib;
  logic [CRC_W-1:0] crc_q, crc_d;

  mc_hash_seq #(
    .DA_NIBS (DA_NIBS),
    .SFD_NIB (SFD_NIB)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rx_dv_i       (rx_dv_i),
    .rxd_i         (rxd_i),
    .data_nib_o    (data_nib),
    .first_nib_o   (first_nib),
    .last_da_nib_o (last_da_nib)
  );

  mc_hash_lfsr_step #(
    .CRC_W (CRC_W),
    .DW    (NIB_W),
    .POLY  (CRC_POLY)
  ) u_step (
    .crc_i  (crc_q),
    .data_i (rxd_i),
    .crc_o  (crc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= CRC_PRESET;
    else if (!rx_dv_i) crc_q <= CRC_PRESET;
    else if (data_nib) crc_q <= crc_d;
  end

  mc_hash_capture #(
    .IDX_W (IDX_W)
  ) u_cap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rx_dv_i       (rx_dv_i),
    .first_nib_i   (first_nib),
    .group_bit_i   (rxd_i[0]),
    .last_da_nib_i (last_da_nib),
    .idx_i         (crc_d[CRC_W-1 -: IDX_W]),
    .idx_o         (hash_idx_o),
    .valid_o       (hash_valid_o)
  );
endmodule

// File: rtl/mc_hash_gen_chk.sv
module mc_hash_gen_chk #(
  parameter int unsigned IDX_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_dv_i,
  input logic [IDX_W-1:0] hash_idx_o,
  input logic             hash_valid_o
);
  // R7
  eof_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dv_i |=> (!hash_valid_o && hash_idx_o == '0));

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hash_valid_o && rx_dv_i) |=> (hash_valid_o && $stable(hash_idx_o)));

  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hash_valid_o |-> (hash_idx_o == '0));

  // R8
  rise_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hash_valid_o) |-> $past(rx_dv_i));

  // R1
  always_comb begin
    if (!rst_ni) reset_idle_chk: assert (!hash_valid_o);
  end
endmodule

bind mc_hash_gen mc_hash_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_dv_i      (rx_dv_i),
  .hash_idx_o   (hash_idx_o),
  .hash_valid_o (hash_valid_o)
);

// File: tb/mc_hash_gen_test.sv
module mc_hash_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_dv_i = 1'b0;
  logic [3:0] rxd_i = 4'h0;
  logic [8:0] hash_idx_o;
  logic       hash_valid_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  mc_hash_gen uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_dv_i      (rx_dv_i),
    .rxd_i        (rxd_i),
    .hash_idx_o   (hash_idx_o),
    .hash_valid_o (hash_valid_o)
  );

  function automatic logic [8:0] ref_idx(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ da[i];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    return c[31:23];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_nib(input logic [3:0] n);
    @(negedge clk_i);
    rx_dv_i = 1'b1;
    rxd_i = n;
  endtask

  task automatic preamble(input int len);
    for (int i = 0; i < len; i++) drive_nib(4'h5);
    drive_nib(4'hD);
  endtask

  // nibbles [from, to) of the address, low nibble of each byte first
  task automatic send_da(input logic [47:0] da, input int from, input int to);
    for (int i = from; i < to; i++) drive_nib(da[i*4 +: 4]);
  endtask

  task automatic end_frame();
    @(negedge clk_i);
    rx_dv_i = 1'b0;
    rxd_i = 4'h0;
    @(posedge clk_i); #1;
    check("R7 valid after end", 32'(hash_valid_o), 0);
    check("R7 idx after end", 32'(hash_idx_o), 0);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    #1;
    check("R1 valid in reset", 32'(hash_valid_o), 0);
    check("R1 idx in reset", 32'(hash_idx_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 valid after reset", 32'(hash_valid_o), 0);
    check("R9 idx after reset", 32'(hash_idx_o), 0);
  endtask

  task automatic t_mcast(input logic [47:0] da, input int pre);
    preamble(pre);
    send_da(da, 0, 11);
    @(posedge clk_i); #1;
    check("R4 valid before 12th nibble", 32'(hash_valid_o), 0);
    send_da(da, 11, 12);
    @(posedge clk_i); #1;
    check("R4 valid after address", 32'(hash_valid_o), 1);
    check("R3 R4 index value", 32'(hash_idx_o), 32'(ref_idx(da)));
    for (int i = 0; i < 10; i++) drive_nib(4'(i * 7 + 3));
    @(posedge clk_i); #1;
    check("R6 valid held in payload", 32'(hash_valid_o), 1);
    check("R6 index held in payload", 32'(hash_idx_o), 32'(ref_idx(da)));
    end_frame();
  endtask

  task automatic t_preamble_len();
    logic [47:0] da = 48'hFB00_005E_0001;
    // preamble nibbles other than 4'hD, and a longer run, do not matter
    drive_nib(4'h5); drive_nib(4'hA); drive_nib(4'h0);
    preamble(9);
    send_da(da, 0, 12);
    @(posedge clk_i); #1;
    check("R2 valid with long preamble", 32'(hash_valid_o), 1);
    check("R2 index with long preamble", 32'(hash_idx_o), 32'(ref_idx(da)));
    end_frame();
  endtask

  task automatic t_unicast();
    logic [47:0] da = 48'h5544_3322_1100;
    preamble(15);
    send_da(da, 0, 12);
    for (int i = 0; i < 6; i++) begin
      drive_nib(4'hF);
      @(posedge clk_i); #1;
      if (i == 0 || i == 5) begin
        check("R5 unicast valid", 32'(hash_valid_o), 0);
        check("R9 unicast idx", 32'(hash_idx_o), 0);
      end
    end
    end_frame();
  endtask

  task automatic t_short();
    logic [47:0] da = 48'hFFFF_FFFF_FFFF;
    preamble(15);
    send_da(da, 0, 11);
    end_frame();
    for (int i = 0; i < 4; i++) @(posedge clk_i);
    #1;
    check("R8 short frame valid", 32'(hash_valid_o), 0);
    check("R8 short frame idx", 32'(hash_idx_o), 0);
  endtask

  task automatic t_back2back();
    logic [47:0] da_a = 48'h0302_0100_0033;
    logic [47:0] da_b = 48'hFB00_005E_0001;
    preamble(15);
    send_da(da_a, 0, 12);
    @(posedge clk_i); #1;
    check("R4 first frame idx", 32'(hash_idx_o), 32'(ref_idx(da_a)));
    @(negedge clk_i);
    rx_dv_i = 1'b0;
    rxd_i = 4'h0;
    preamble(15);
    send_da(da_b, 0, 12);
    @(posedge clk_i); #1;
    check("R7 second frame valid", 32'(hash_valid_o), 1);
    check("R7 second frame idx fresh", 32'(hash_idx_o), 32'(ref_idx(da_b)));
    end_frame();
  endtask

  initial begin
    t_reset();
    t_mcast(48'hFB00_005E_0001, 15);
    t_mcast(48'hFFFF_FFFF_FFFF, 3);
    t_mcast(48'hA5C3_0F96_7E13, 7);
    t_preamble_len();
    t_unicast();
    t_short();
    t_back2back();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG_CYCLES; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule